// File: doc/BRIEF.md
# External and Pin-Change Interrupt Detector

This block watches one dedicated trigger pin and a group of general pins and turns their activity into interrupt requests for a small processor core. The trigger pin has a two-bit sense setting. It can request while it is held low, or it can latch a sticky flag on any change, on a falling edge or on a rising edge. The general pins share one sticky flag. That flag sets when any pin whose mask bit is one toggles, in either direction. Each source has an enable. A request is raised only when the enable is set together with the flag, or together with the low level in level mode. The core clears a flag with an acknowledge strobe, and software clears it with a write-one strobe.

Pins are sampled as plain inputs, so activity that the chip itself drives onto a pin raises an interrupt just like external activity. Software uses this to trigger an interrupt on purpose. The clocked detection path passes the pins through a two-flop synchroniser. That path runs only while `io_clk_run` is high, which models an I/O clock that runs in idle sleep and is stopped in the deeper sleep modes. A separate combinational wake output needs no clock. It reports a low level on the trigger pin in level mode, and any masked general pin whose value differs from its last clocked sample. This lets the part wake from sleep modes that stop the I/O clock.

Top module: `pin_irq_detector`

## Requirements
- R1: While `rst` is high, and in the cycle after it, both flags and both requests are 0.
- R2: With `trig_sense` = 00 (level), `trig_req` equals `trig_en` while the synchronised trigger pin is low. `trig_req` follows a pin change two clock cycles later, and `trig_flag` stays 0.
- R3: With `trig_sense` = 01 (any change), 10 (falling) or 11 (rising), a matching trigger-pin transition sets `trig_flag` on the third clock edge after the change. A non-matching transition leaves the flag clear.
- R4: Both flags set whether or not their enables are on. `trig_req` (in an edge mode) equals `trig_en` AND `trig_flag`, and `grp_req` equals `grp_en` AND `grp_flag`.
- R5: A one on the acknowledge input or the clear input of a source clears that flag at the next edge. If a new event arrives at the same edge, the flag stays set.
- R6: A change of `trig_sense` clears `trig_flag` at the next edge, and any edge seen in that cycle is dropped.
- R7: A toggle in either direction on general pin i sets `grp_flag` three edges later if `grp_mask[i]` is 1, and has no effect if it is 0.
- R8: While `io_clk_run` is 0, no flag sets. A trigger pulse that starts and ends inside the halt is never flagged. A masked general-pin change that is still present when the clock resumes sets `grp_flag` three edges after the resume.
- R9: `wake` is a combinational output with no clock path. It is high when `trig_en` is set, `trig_sense` = 00 and the raw trigger pin is low. It is also high when `grp_en` is set and some masked raw general pin differs from its last clocked sample.
- R10: After reset, no flag is set by the reset values of the synchroniser. Edge detection starts only once the sampling chain holds real pin samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| io_clk_run | input | 1 | High while the I/O clock runs; low stops the sampled path |
| trig_pin | input | 1 | Dedicated trigger pin |
| trig_sense | input | 2 | Sense setting: 00 low level, 01 any change, 10 falling, 11 rising |
| trig_en | input | 1 | Trigger request enable |
| trig_ack | input | 1 | Core acknowledge for the trigger flag |
| trig_clr | input | 1 | Software write-one clear for the trigger flag |
| grp_pins | input | NPC | General pins |
| grp_mask | input | NPC | Per-pin participation mask |
| grp_en | input | 1 | Pin-change request enable |
| grp_ack | input | 1 | Core acknowledge for the pin-change flag |
| grp_clr | input | 1 | Software write-one clear for the pin-change flag |
| trig_flag | output | 1 | Sticky trigger edge flag |
| trig_req | output | 1 | Trigger interrupt request |
| grp_flag | output | 1 | Sticky pin-change flag |
| grp_req | output | 1 | Pin-change interrupt request |
| wake | output | 1 | Clock-free wake indication |

## Verification
The checker checks several properties on every cycle. A request never appears without its enable, and in edge modes never without its flag. Level mode never holds a flag. A sense change empties the trigger flag. No flag rises while the I/O clock is stopped. An acknowledge given during a halt always clears. A raw low level in level mode always raises wake. Other properties depend on particular input histories, so only the bench scenarios show them:
- the exact edge on which each sense mode latches;
- the sweep of every mask against every general pin;
- the set-versus-acknowledge collision;
- a short pulse lost inside a halt;
- a masked change carried across a halt and caught when the clock resumes.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;

    // Sense setting of the dedicated trigger pin
    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_ANY  = 2'b01,
        SENSE_FALL = 2'b10,
        SENSE_RISE = 2'b11
    } sense_e;

    // Clear strobes of one interrupt source
    typedef struct packed {
        logic ack;
        logic w1c;
    } clr_req_t;

    // Does the transition prev -> cur qualify under the given sense?
    function automatic logic edge_match(sense_e mode, logic prev, logic cur);
        logic hit;
        case (mode)
            SENSE_ANY:  hit = prev ^ cur;
            SENSE_FALL: hit = prev & ~cur;
            SENSE_RISE: hit = ~prev & cur;
            default:    hit = 1'b0;
        endcase
        return hit;
    endfunction

    // Sticky flag next-state: drop beats set, set beats clear
    function automatic logic flag_next(logic cur_flag, logic drop, logic set, clr_req_t clr);
        logic nxt;
        if (drop)
            nxt = 1'b0;
        else if (set)
            nxt = 1'b1;
        else if (clr.ack || clr.w1c)
            nxt = 1'b0;
        else
            nxt = cur_flag;
        return nxt;
    endfunction

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int W      = 7,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic [W-1:0] d,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev,
    output logic         primed
);
    // STAGES synchroniser flops plus one history flop for edge compare
    localparam int DEPTH = STAGES + 1;
    localparam int CW    = $clog2(DEPTH + 1);

    logic [DEPTH-1:0][W-1:0] chain;
    logic [CW-1:0]           fill;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else if (run) begin
            for (int k = DEPTH - 1; k > 0; k--) begin
                chain[k] <= chain[k-1];
            end
            chain[0] <= d;
        end
    end

    // Counts sampled cycles until every stage holds a real pin value
    always_ff @(posedge clk) begin
        if (rst)
            fill <= '0;
        else if (run && fill != CW'(DEPTH))
            fill <= fill + 1'b1;
    end

    assign cur    = chain[STAGES-1];
    assign prev   = chain[STAGES];
    assign primed = (fill == CW'(DEPTH));

endmodule

// File: rtl/trig_sense_unit.sv
module trig_sense_unit
    import pin_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     run,
    input  logic     primed,
    input  sense_e   mode,
    input  logic     cur,
    input  logic     prev,
    input  logic     en,
    input  clr_req_t clr,
    output logic     flag,
    output logic     req
);
    sense_e mode_q;
    logic   mode_changed;
    logic   edge_hit;

    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= SENSE_LOW;
        else
            mode_q <= mode;
    end

    assign mode_changed = (mode != mode_q);
    assign edge_hit     = run && primed && (mode != SENSE_LOW) && edge_match(mode, prev, cur);

    always_ff @(posedge clk) begin
        if (rst)
            flag <= 1'b0;
        else
            flag <= flag_next(flag, mode_changed, edge_hit, clr);
    end

    // Level mode bypasses the flag and follows the sampled pin
    always_comb begin
        if (mode == SENSE_LOW)
            req = en && primed && !cur;
        else
            req = en && flag;
    end

endmodule

// File: rtl/grp_change_unit.sv
module grp_change_unit
    import pin_irq_pkg::*;
#(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         primed,
    input  logic [N-1:0] mask,
    input  logic [N-1:0] cur,
    input  logic [N-1:0] prev,
    input  logic [N-1:0] raw,
    input  logic         en,
    input  clr_req_t     clr,
    output logic         flag,
    output logic         req,
    output logic         wake
);
    logic [N-1:0] toggled;
    logic [N-1:0] drift;
    logic         change_hit;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_pin
            // clocked path: consecutive samples differ
            assign toggled[g] = mask[g] & (cur[g] ^ prev[g]);
            // clock-free path: raw pin differs from last sample
            assign drift[g]   = mask[g] & (raw[g] ^ cur[g]);
        end
    endgenerate

    assign change_hit = run && primed && (|toggled);

    always_ff @(posedge clk) begin
        if (rst)
            flag <= 1'b0;
        else
            flag <= flag_next(flag, 1'b0, change_hit, clr);
    end

    assign req  = en && flag;
    assign wake = en && primed && (|drift);

endmodule

// File: rtl/pin_irq_detector.sv
module pin_irq_detector
    import pin_irq_pkg::*;
#(
    parameter int NPC         = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           io_clk_run,
    input  logic           trig_pin,
    input  logic [1:0]     trig_sense,
    input  logic           trig_en,
    input  logic           trig_ack,
    input  logic           trig_clr,
    input  logic [NPC-1:0] grp_pins,
    input  logic [NPC-1:0] grp_mask,
    input  logic           grp_en,
    input  logic           grp_ack,
    input  logic           grp_clr,
    output logic           trig_flag,
    output logic           trig_req,
    output logic           grp_flag,
    output logic           grp_req,
    output logic           wake
);
    localparam int SW = NPC + 1;

    logic [SW-1:0] s_cur, s_prev;
    logic          primed;
    sense_e        mode;
    clr_req_t      trig_clr_s, grp_clr_s;
    logic          grp_wake;

    assign mode       = sense_e'(trig_sense);
    assign trig_clr_s = '{ack: trig_ack, w1c: trig_clr};
    assign grp_clr_s  = '{ack: grp_ack,  w1c: grp_clr};

    // Bit 0 carries the trigger pin, bits NPC:1 the general pins
    pin_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .run    (io_clk_run),
        .d      ({grp_pins, trig_pin}),
        .cur    (s_cur),
        .prev   (s_prev),
        .primed (primed)
    );

    trig_sense_unit u_trig (
        .clk    (clk),
        .rst    (rst),
        .run    (io_clk_run),
        .primed (primed),
        .mode   (mode),
        .cur    (s_cur[0]),
        .prev   (s_prev[0]),
        .en     (trig_en),
        .clr    (trig_clr_s),
        .flag   (trig_flag),
        .req    (trig_req)
    );

    grp_change_unit #(.N(NPC)) u_grp (
        .clk    (clk),
        .rst    (rst),
        .run    (io_clk_run),
        .primed (primed),
        .mask   (grp_mask),
        .cur    (s_cur[SW-1:1]),
        .prev   (s_prev[SW-1:1]),
        .raw    (grp_pins),
        .en     (grp_en),
        .clr    (grp_clr_s),
        .flag   (grp_flag),
        .req    (grp_req),
        .wake   (grp_wake)
    );

    // Clock-free wake: raw low level in level mode, or masked pin drift
    assign wake = grp_wake || (trig_en && (mode == SENSE_LOW) && !trig_pin);

endmodule

// File: rtl/pin_irq_checker.sv
module pin_irq_checker (
    input logic       clk,
    input logic       rst,
    input logic       io_clk_run,
    input logic       trig_pin,
    input logic [1:0] trig_sense,
    input logic       trig_en,
    input logic       grp_en,
    input logic       grp_ack,
    input logic       trig_flag,
    input logic       trig_req,
    input logic       grp_flag,
    input logic       grp_req,
    input logic       wake
);

    AST_LEVEL_NO_FLAG: assert property (@(posedge clk) disable iff (rst)
        (trig_sense == 2'b00 && $past(trig_sense) == 2'b00) |-> !trig_flag); // R2

    AST_TRIG_REQ_GATED: assert property (@(posedge clk) disable iff (rst)
        (trig_req && trig_sense != 2'b00) |-> (trig_en && trig_flag)); // R4

    AST_GRP_REQ_GATED: assert property (@(posedge clk) disable iff (rst)
        grp_req |-> (grp_en && grp_flag)); // R4

    AST_HALT_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        ($past(grp_ack) && !$past(io_clk_run)) |-> !grp_flag); // R5

    AST_SENSE_CHANGE_DROPS: assert property (@(posedge clk) disable iff (rst)
        (trig_sense != $past(trig_sense)) |=> !trig_flag); // R6

    AST_TRIG_NO_SET_HALTED: assert property (@(posedge clk) disable iff (rst)
        $rose(trig_flag) |-> $past(io_clk_run)); // R8

    AST_GRP_NO_SET_HALTED: assert property (@(posedge clk) disable iff (rst)
        $rose(grp_flag) |-> $past(io_clk_run)); // R8

    AST_LEVEL_WAKES: assert property (@(posedge clk) disable iff (rst)
        (trig_en && trig_sense == 2'b00 && !trig_pin) |-> wake); // R9

endmodule

bind pin_irq_detector pin_irq_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .io_clk_run (io_clk_run),
    .trig_pin   (trig_pin),
    .trig_sense (trig_sense),
    .trig_en    (trig_en),
    .grp_en     (grp_en),
    .grp_ack    (grp_ack),
    .trig_flag  (trig_flag),
    .trig_req   (trig_req),
    .grp_flag   (grp_flag),
    .grp_req    (grp_req),
    .wake       (wake)
);

// File: tb/tb_pin_irq_detector.sv
`timescale 1ns/1ps
module tb_pin_irq_detector;
    localparam int NPC = 6;

    logic           clk = 1'b0;
    logic           rst, io_clk_run, trig_pin, trig_en, trig_ack, trig_clr;
    logic [1:0]     trig_sense;
    logic [NPC-1:0] grp_pins, grp_mask;
    logic           grp_en, grp_ack, grp_clr;
    logic           trig_flag, trig_req, grp_flag, grp_req, wake;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #4 clk = ~clk; // 125 MHz

    pin_irq_detector #(.NPC(NPC), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst(rst), .io_clk_run(io_clk_run),
        .trig_pin(trig_pin), .trig_sense(trig_sense), .trig_en(trig_en),
        .trig_ack(trig_ack), .trig_clr(trig_clr),
        .grp_pins(grp_pins), .grp_mask(grp_mask), .grp_en(grp_en),
        .grp_ack(grp_ack), .grp_clr(grp_clr),
        .trig_flag(trig_flag), .trig_req(trig_req),
        .grp_flag(grp_flag), .grp_req(grp_req), .wake(wake)
    );

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk(input logic act, input logic exp, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", what, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    task automatic pulse_trig_clr();
        trig_clr = 1'b1; tick(); trig_clr = 1'b0;
    endtask

    task automatic pulse_grp_clr();
        grp_clr = 1'b1; tick(); grp_clr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        report();
    end

    initial begin
        logic exp;
        rst = 1'b1; io_clk_run = 1'b1;
        trig_pin = 1'b1; trig_sense = 2'b11; trig_en = 1'b1;
        trig_ack = 1'b0; trig_clr = 1'b0;
        grp_pins = 6'h2A; grp_mask = 6'h3F; grp_en = 1'b1;
        grp_ack = 1'b0; grp_clr = 1'b0;
        tick(3);
        // R1: reset state
        chk(trig_flag, 1'b0, "R1 trig_flag in reset");
        chk(grp_flag,  1'b0, "R1 grp_flag in reset");
        chk(trig_req,  1'b0, "R1 trig_req in reset");
        chk(grp_req,   1'b0, "R1 grp_req in reset");
        rst = 1'b0;
        tick();
        chk(trig_flag, 1'b0, "R1 trig_flag after reset");
        chk(grp_flag,  1'b0, "R1 grp_flag after reset");
        tick(6);
        // R10: pins high vs. zeroed chain must not look like edges
        chk(trig_flag, 1'b0, "R10 no spurious trig edge");
        chk(grp_flag,  1'b0, "R10 no spurious grp change");

        // R2: level mode
        trig_sense = 2'b00; trig_en = 1'b1; grp_en = 1'b0;
        tick();
        trig_pin = 1'b0;
        tick();
        chk(trig_req, 1'b0, "R2 level req after one edge");
        tick();
        chk(trig_req,  1'b1, "R2 level req after two edges");
        chk(trig_flag, 1'b0, "R2 level keeps flag clear");
        trig_en = 1'b0; #1;
        chk(trig_req, 1'b0, "R2 level req needs enable");
        trig_en = 1'b1;
        trig_pin = 1'b1;
        tick(2);
        chk(trig_req, 1'b0, "R2 level req drops with pin high");

        // R3 / R4: edge modes, both directions, enable alternating
        for (int m = 1; m <= 3; m++) begin
            for (int dir = 0; dir < 2; dir++) begin
                trig_sense = 2'(m);
                trig_en    = dir[0];
                trig_pin   = (dir == 0) ? 1'b1 : 1'b0;
                tick(4);
                pulse_trig_clr();
                chk(trig_flag, 1'b0, "R5 clear strobe empties trig flag");
                trig_pin = ~trig_pin;
                tick(2);
                chk(trig_flag, 1'b0, "R3 flag not yet set after two edges");
                tick();
                exp = (m == 1) || (m == 2 && dir == 0) || (m == 3 && dir == 1);
                chk(trig_flag, exp, $sformatf("R3 mode %0d dir %0d", m, dir));
                chk(trig_req, exp & dir[0], $sformatf("R4 trig_req mode %0d en %0d", m, dir));
            end
        end

        // R5: event and acknowledge on the same edge -> flag stays set
        trig_sense = 2'b01; trig_en = 1'b1;
        tick(4);
        pulse_trig_clr();
        trig_pin = ~trig_pin;
        tick(2);
        trig_ack = 1'b1; tick(); trig_ack = 1'b0;
        chk(trig_flag, 1'b1, "R5 set wins over ack");
        trig_ack = 1'b1; tick(); trig_ack = 1'b0;
        chk(trig_flag, 1'b0, "R5 ack clears trig flag");
        chk(trig_req,  1'b0, "R5 req gone after ack");

        // R6: sense change drops a pending flag
        trig_sense = 2'b10; trig_pin = 1'b1;
        tick(4);
        pulse_trig_clr();
        trig_pin = 1'b0;
        tick(4);
        chk(trig_flag, 1'b1, "R3 falling edge flagged");
        trig_sense = 2'b11;
        tick();
        chk(trig_flag, 1'b0, "R6 sense change clears flag");
        tick(2);
        chk(trig_flag, 1'b0, "R6 flag stays clear");

        // R8: pulse inside a halt is lost
        trig_sense = 2'b10; trig_pin = 1'b1;
        tick(4);
        pulse_trig_clr();
        io_clk_run = 1'b0;
        trig_pin = 1'b0; tick(2);
        trig_pin = 1'b1; tick(2);
        chk(trig_flag, 1'b0, "R8 no flag while halted");
        io_clk_run = 1'b1;
        tick(4);
        chk(trig_flag, 1'b0, "R8 halted pulse never flagged");

        // R9: clock-free wake paths while halted
        trig_sense = 2'b00; trig_en = 1'b1; grp_en = 1'b0;
        grp_mask = 6'b000100; grp_pins = 6'h00;
        tick(4);
        pulse_grp_clr();
        io_clk_run = 1'b0;
        #1;
        chk(wake, 1'b0, "R9 no wake with pin high");
        trig_pin = 1'b0; #1;
        chk(wake, 1'b1, "R9 low level wakes");
        trig_en = 1'b0; #1;
        chk(wake, 1'b0, "R9 level wake needs enable");
        trig_pin = 1'b1; trig_en = 1'b1;
        grp_en = 1'b1;
        grp_pins[0] = 1'b1; #1;
        chk(wake, 1'b0, "R9 unmasked pin does not wake");
        grp_pins[2] = 1'b1; #1;
        chk(wake, 1'b1, "R9 masked pin change wakes");
        tick(3);
        chk(grp_flag, 1'b0, "R8 grp flag held while halted");
        grp_ack = 1'b1; tick(); grp_ack = 1'b0;
        io_clk_run = 1'b1;
        tick(2);
        chk(grp_flag, 1'b0, "R8 grp flag not yet after resume");
        tick();
        chk(grp_flag, 1'b1, "R8 masked change caught after resume");
        chk(grp_req,  1'b1, "R4 grp_req with enable");
        tick(2);
        chk(wake, 1'b0, "R9 wake drops once sampled");

        // R7: every mask against every pin
        for (int mk = 0; mk < 64; mk++) begin
            for (int p = 0; p < NPC; p++) begin
                grp_mask = 6'(mk);
                grp_en   = p[0];
                pulse_grp_clr();
                grp_pins[p] = ~grp_pins[p];
                tick(3);
                exp = grp_mask[p];
                chk(grp_flag, exp, $sformatf("R7 mask %02h pin %0d", mk, p));
                chk(grp_req, exp & p[0], $sformatf("R4 grp_req mask %02h pin %0d", mk, p));
            end
        end

        report();
    end
endmodule